// File: doc/BRIEF.md
# Amplifier Fault Protection Supervisor

This block is the synchronous decision point that sits between the digitised health flags of a two-channel switching power amplifier and its output bridges. Every clock cycle it looks at a junction-temperature code, one over-current comparator flag per bridge output, three under-voltage flags (main rail, charge pump, 5 V regulator), the mute and sleep pins and an input-overload flag. From these it decides whether the bridges switch, sit idle in mute, or are released to high impedance. It also raises a fault indicator, a low-power request and an active-low overload indicator.

Over-temperature recovers by itself through a hysteresis band. An over-current event is sticky. It is released only by a full mute toggle (rise, then fall) or by reset. The first half of the toggle already withdraws the over-current contribution to the fault output, so the fault output can be wired straight back to the mute pin and the block recovers by itself, with no combinational loop. The mute, sleep and overload pins are asynchronous and pass through a flop synchroniser. The condition flags and the temperature code are taken as synchronous to the clock.

Top module: `amp_fault_supervisor`

## Requirements
- R1: When `temp_code` is greater than `TEMP_SET` (default 155) in a cycle, `fault_o` is 1 from the next cycle on, and `hiz_o` is 1 as well.
- R2: The over-temperature condition clears only when `temp_code` is below `TEMP_CLR` (default 110). A code in the inclusive band [`TEMP_CLR`, `TEMP_SET`] keeps the previous over-temperature state.
- R3: When any bit of `oc_flag` is 1 while the block is not asleep, the over-current trip is latched and `fault_o` is 1 from the next cycle on. The trip stays after every flag returns to 0.
- R4: A latched trip is released by a mute toggle or by reset. A rising edge of the synchronised mute withdraws the trip from `fault_o` while the bridges stay disabled. The following falling edge returns the block to normal. With `mute_pin` driven by `fault_o`, the block recovers from a single over-current pulse on its own.
- R5: Any of `uv_main`, `uv_pump`, `uv_reg5` at 1 gives `fault_o` = 1 in the next cycle. With all three at 0, `fault_o` falls in the next cycle, provided no other fault holds it.
- R6: While `fault_o` is 1, `hiz_o` is 1 and `bridge_en_o` is 0.
- R7: `mute_pin` at 1, seen two clock edges later, gives `bridge_en_o` = 0 with `hiz_o` = 0 (idle, not released). Once mute returns low and there is no fault and no sleep, `bridge_en_o` is 1.
- R8: `sleep_pin` at 1, seen two edges later, gives `lowpwr_o` = 1, `hiz_o` = 1 and `bridge_en_o` = 0, whatever the state of mute.
- R9: While asleep, the over-current latch state is frozen. It is neither set by `oc_flag` nor cleared by mute edges.
- R10: `ovl_n_o` is the inverse of `ovl_in`, delayed by two clock edges.
- R11: During reset `fault_o`, `hiz_o`, `bridge_en_o` and `lowpwr_o` are 0 and `ovl_n_o` is 1, and reset clears the over-current latch. After reset the block behaves as muted until a low mute has passed the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power cycle) |
| temp_code | input | TEMP_W | Junction temperature code, one unit per degree |
| oc_flag | input | NUM_OUT | Over-current comparator flag per bridge output |
| uv_main | input | 1 | Main supply below threshold |
| uv_pump | input | 1 | Charge-pump voltage below threshold |
| uv_reg5 | input | 1 | 5 V regulator below threshold |
| mute_pin | input | 1 | Mute request, asynchronous, high = mute |
| sleep_pin | input | 1 | Sleep request, asynchronous, high = low power |
| ovl_in | input | 1 | Input-overload detector, asynchronous |
| fault_o | output | 1 | Fault indicator, high on any fault |
| ovl_n_o | output | 1 | Overload indicator, active low |
| bridge_en_o | output | 1 | Bridges allowed to switch |
| hiz_o | output | 1 | All bridge outputs to high impedance |
| lowpwr_o | output | 1 | Low-quiescent-current request |

## Verification
The assertions assume that `temp_code`, `oc_flag` and the under-voltage flags change only between clock edges, because the block samples them without a synchroniser. They also assume that the pins are quiet across reset, so that the mute edge history after release begins from a known muted state. The stimulus drives every input one time unit after a rising edge and holds it for whole cycles. It keeps the pins at fixed values while reset is low. The temperature sweep walks every code up and then down, so the hysteresis band is entered from both sides.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

   // Over-current latch states
   typedef enum logic [1:0] {
      OC_CLEAR = 2'd0,   // no trip, bridges may run
      OC_TRIP  = 2'd1,   // trip latched, fault raised
      OC_ARMED = 2'd2    // mute rose after trip, waiting for mute fall
   } oc_state_e;

   // Index of each pin inside the synchroniser bundle
   localparam int PIN_MUTE  = 0;
   localparam int PIN_SLEEP = 1;
   localparam int PIN_OVL   = 2;
   localparam int PIN_COUNT = 3;

endpackage

// File: rtl/amp_sup_sync.sv
module amp_sup_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("amp_sup_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q <= RST_VAL;
         else        stage_q <= d;
      end
      assign q = stage_q;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/amp_sup_thermal.sv
module amp_sup_thermal #(
   parameter int TEMP_W   = 8,
   parameter int TEMP_SET = 155,
   parameter int TEMP_CLR = 110,
   parameter bit HYST_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_code,
   output logic              ot_q
);

   localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(TEMP_SET);
   localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(TEMP_CLR);

   if (HYST_EN) begin : g_hyst
      if (TEMP_CLR > TEMP_SET) begin : g_bad_band
         $error("amp_sup_thermal: TEMP_CLR above TEMP_SET");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     ot_q <= 1'b0;
         else if (temp_code > SET_CODE)  ot_q <= 1'b1;
         else if (temp_code < CLR_CODE)  ot_q <= 1'b0;
      end
   end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ot_q <= 1'b0;
         else        ot_q <= (temp_code > SET_CODE);
      end
   end

endmodule

// File: rtl/amp_sup_ocp.sv
module amp_sup_ocp
   import amp_sup_pkg::*;
#(
   parameter int NUM_OUT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] oc_flag,
   input  logic               mute_s,
   input  logic               hold,
   output oc_state_e          state_q,
   output logic               trip_o,
   output logic               run_ok_o
);

   logic      mute_d;
   logic      mute_rise;
   logic      mute_fall;
   logic      any_oc;
   oc_state_e state_d;

   // Previous mute sample, reset as muted so release shows no false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mute_d <= 1'b1;
      else        mute_d <= mute_s;
   end

   assign mute_rise = mute_s & ~mute_d;
   assign mute_fall = ~mute_s & mute_d;
   assign any_oc    = |oc_flag;

   always_comb begin
      state_d = state_q;
      if (!hold) begin
         if (any_oc) begin
            state_d = OC_TRIP;
         end else begin
            unique case (state_q)
               OC_TRIP:  if (mute_rise) state_d = OC_ARMED;
               OC_ARMED: if (mute_fall) state_d = OC_CLEAR;
               default:  state_d = OC_CLEAR;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= OC_CLEAR;
      else        state_q <= state_d;
   end

   assign trip_o   = (state_q == OC_TRIP);
   assign run_ok_o = (state_q == OC_CLEAR);

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
   import amp_sup_pkg::*;
#(
   parameter int TEMP_W      = 8,
   parameter int TEMP_SET    = 155,
   parameter int TEMP_CLR    = 110,
   parameter bit HYST_EN     = 1'b1,
   parameter int NUM_OUT     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TEMP_W-1:0]  temp_code,
   input  logic [NUM_OUT-1:0] oc_flag,
   input  logic               uv_main,
   input  logic               uv_pump,
   input  logic               uv_reg5,
   input  logic               mute_pin,
   input  logic               sleep_pin,
   input  logic               ovl_in,
   output logic               fault_o,
   output logic               ovl_n_o,
   output logic               bridge_en_o,
   output logic               hiz_o,
   output logic               lowpwr_o
);

   localparam int                 TEMP_MAX = (1 << TEMP_W) - 1;
   localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1 << PIN_MUTE);

   if (TEMP_SET >= TEMP_MAX) begin : g_bad_set
      $error("amp_fault_supervisor: TEMP_SET does not fit below the code range top");
   end
   if (NUM_OUT < 1) begin : g_bad_outs
      $error("amp_fault_supervisor: NUM_OUT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("amp_fault_supervisor: SYNC_STAGES must be at least 2");
   end

   logic [PIN_COUNT-1:0] pin_raw;
   logic [PIN_COUNT-1:0] pin_s;
   logic                 mute_s;
   logic                 sleep_s;
   logic                 ovl_s;
   logic                 ot_q;
   logic                 uv_q;
   oc_state_e            oc_state;
   logic                 oc_trip;
   logic                 oc_run_ok;

   // Pin synchroniser, mute resets high so the block starts muted
   always_comb begin
      pin_raw            = '0;
      pin_raw[PIN_MUTE]  = mute_pin;
      pin_raw[PIN_SLEEP] = sleep_pin;
      pin_raw[PIN_OVL]   = ovl_in;
   end

   amp_sup_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   assign mute_s  = pin_s[PIN_MUTE];
   assign sleep_s = pin_s[PIN_SLEEP];
   assign ovl_s   = pin_s[PIN_OVL];

   amp_sup_thermal #(
      .TEMP_W   (TEMP_W),
      .TEMP_SET (TEMP_SET),
      .TEMP_CLR (TEMP_CLR),
      .HYST_EN  (HYST_EN)
   ) u_thermal (
      .clk       (clk),
      .rst_n     (rst_n),
      .temp_code (temp_code),
      .ot_q      (ot_q)
   );

   amp_sup_ocp #(
      .NUM_OUT (NUM_OUT)
   ) u_ocp (
      .clk      (clk),
      .rst_n    (rst_n),
      .oc_flag  (oc_flag),
      .mute_s   (mute_s),
      .hold     (sleep_s),
      .state_q  (oc_state),
      .trip_o   (oc_trip),
      .run_ok_o (oc_run_ok)
   );

   // Supply monitors, registered so every fault source has one cycle of latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) uv_q <= 1'b0;
      else        uv_q <= uv_main | uv_pump | uv_reg5;
   end

   // Output decisions, all driven from flops, no path from mute_pin to fault_o
   assign fault_o     = ot_q | uv_q | oc_trip;
   assign hiz_o       = fault_o | sleep_s;
   assign lowpwr_o    = sleep_s;
   assign bridge_en_o = ~fault_o & ~sleep_s & ~mute_s & oc_run_ok;
   assign ovl_n_o     = ~ovl_s;

endmodule

// File: rtl/amp_sup_checker.sv
module amp_sup_checker
   import amp_sup_pkg::*;
#(
   parameter int TEMP_W   = 8,
   parameter int TEMP_SET = 155,
   parameter int TEMP_CLR = 110,
   parameter int NUM_OUT  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [TEMP_W-1:0]  temp_code,
   input logic [NUM_OUT-1:0] oc_flag,
   input logic               uv_main,
   input logic               uv_pump,
   input logic               uv_reg5,
   input logic               fault_o,
   input logic               bridge_en_o,
   input logic               hiz_o,
   input logic               lowpwr_o,
   input logic               ot_q,
   input logic               mute_s,
   input logic               sleep_s,
   input logic [1:0]         oc_state
);

   localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(TEMP_SET);
   localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(TEMP_CLR);

   AST_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_code > SET_CODE) |=> (fault_o && hiz_o)); // R1

   AST_OT_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_code >= CLR_CODE && temp_code <= SET_CODE) |=> $stable(ot_q)); // R2

   AST_OC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((|oc_flag) && !sleep_s) |=> fault_o); // R3

   AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_state == 2'(OC_TRIP) && !mute_s) |=> (oc_state == 2'(OC_TRIP))); // R4

   AST_UV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_main || uv_pump || uv_reg5) |=> fault_o); // R5

   AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (hiz_o && !bridge_en_o)); // R6

   AST_MUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_s && !fault_o && !sleep_s) |-> (!bridge_en_o && !hiz_o)); // R7

   AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr_o |-> (hiz_o && !bridge_en_o)); // R8

   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_s |=> $stable(oc_state)); // R9

endmodule

bind amp_fault_supervisor amp_sup_checker #(
   .TEMP_W   (TEMP_W),
   .TEMP_SET (TEMP_SET),
   .TEMP_CLR (TEMP_CLR),
   .NUM_OUT  (NUM_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .temp_code   (temp_code),
   .oc_flag     (oc_flag),
   .uv_main     (uv_main),
   .uv_pump     (uv_pump),
   .uv_reg5     (uv_reg5),
   .fault_o     (fault_o),
   .bridge_en_o (bridge_en_o),
   .hiz_o       (hiz_o),
   .lowpwr_o    (lowpwr_o),
   .ot_q        (ot_q),
   .mute_s      (mute_s),
   .sleep_s     (sleep_s),
   .oc_state    (oc_state)
);

// File: tb/amp_fault_supervisor_test.sv
`timescale 1ns/1ps
module amp_fault_supervisor_test;

   localparam int TW   = 8;
   localparam int TSET = 155;
   localparam int TCLR = 110;
   localparam int NO   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] temp_code = '0;
   logic [NO-1:0] oc_flag = '0;
   logic          uv_main = 1'b0, uv_pump = 1'b0, uv_reg5 = 1'b0;
   logic          mute_drv = 1'b1;
   logic          tie_fb = 1'b0;
   logic          sleep_pin = 1'b0;
   logic          ovl_in = 1'b0;
   logic          mute_pin;
   logic          fault_o, ovl_n_o, bridge_en_o, hiz_o, lowpwr_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   assign mute_pin = tie_fb ? fault_o : mute_drv;

   amp_fault_supervisor #(
      .TEMP_W (TW), .TEMP_SET (TSET), .TEMP_CLR (TCLR), .NUM_OUT (NO)
   ) uut (
      .clk (clk), .rst_n (rst_n), .temp_code (temp_code), .oc_flag (oc_flag),
      .uv_main (uv_main), .uv_pump (uv_pump), .uv_reg5 (uv_reg5),
      .mute_pin (mute_pin), .sleep_pin (sleep_pin), .ovl_in (ovl_in),
      .fault_o (fault_o), .ovl_n_o (ovl_n_o), .bridge_en_o (bridge_en_o),
      .hiz_o (hiz_o), .lowpwr_o (lowpwr_o)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Full mute toggle: high long enough to pass sync and edge detect, then low
   task automatic mute_toggle();
      mute_drv = 1'b1;
      tick(4);
      mute_drv = 1'b0;
      tick(4);
   endtask

   initial begin : watchdog
      #200000;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      bit ot_m;
      // R11: reset state
      tick(3);
      chk("R11 fault in reset", int'(fault_o), 0);
      chk("R11 bridge in reset", int'(bridge_en_o), 0);
      chk("R11 hiz in reset", int'(hiz_o), 0);
      chk("R11 lowpwr in reset", int'(lowpwr_o), 0);
      chk("R11 ovl_n in reset", int'(ovl_n_o), 1);
      rst_n = 1'b1;
      tick(4);
      chk("R11 muted after release", int'(bridge_en_o), 0);
      mute_drv = 1'b0;
      tick(1);
      chk("R7 mute low one edge", int'(bridge_en_o), 0);
      tick(1);
      chk("R7 mute low two edges", int'(bridge_en_o), 1);

      // R7: mute high with no fault
      mute_drv = 1'b1;
      tick(1);
      chk("R7 mute high one edge", int'(bridge_en_o), 1);
      tick(1);
      chk("R7 mute high two edges", int'(bridge_en_o), 0);
      chk("R7 mute idle not hiz", int'(hiz_o), 0);
      mute_drv = 1'b0;
      tick(3);
      chk("R7 unmuted", int'(bridge_en_o), 1);

      // R1 R2: temperature sweep up then down, model with hysteresis
      ot_m = 1'b0;
      for (int t = 0; t <= 255; t++) begin
         temp_code = TW'(t);
         tick(1);
         if (t > TSET) ot_m = 1'b1; else if (t < TCLR) ot_m = 1'b0;
         chk((t > TSET) ? "R1 rising sweep" : "R2 rising sweep", int'(fault_o), int'(ot_m));
         if (ot_m) chk("R6 hiz on over-temp", int'(hiz_o), 1);
      end
      for (int t = 255; t >= 0; t--) begin
         temp_code = TW'(t);
         tick(1);
         if (t > TSET) ot_m = 1'b1; else if (t < TCLR) ot_m = 1'b0;
         chk("R2 falling sweep", int'(fault_o), int'(ot_m));
         if (ot_m) chk("R6 bridge off on over-temp", int'(bridge_en_o), 0);
      end
      temp_code = '0;
      tick(1);

      // R5: each supply flag alone
      for (int s = 0; s < 3; s++) begin
         uv_main = (s == 0);
         uv_pump = (s == 1);
         uv_reg5 = (s == 2);
         tick(1);
         chk("R5 supply flag raises fault", int'(fault_o), 1);
         chk("R6 supply fault hiz", int'(hiz_o), 1);
         uv_main = 1'b0; uv_pump = 1'b0; uv_reg5 = 1'b0;
         tick(1);
         chk("R5 supply fault clears", int'(fault_o), 0);
         chk("R5 bridges back", int'(bridge_en_o), 1);
      end

      // R3 R4: each output's flag, sticky, cleared by manual toggle
      for (int b = 0; b < NO; b++) begin
         oc_flag = NO'(1 << b);
         tick(1);
         oc_flag = '0;
         chk("R3 trip raises fault", int'(fault_o), 1);
         tick(8);
         chk("R3 trip sticky", int'(fault_o), 1);
         chk("R6 trip bridges off", int'(bridge_en_o), 0);
         mute_drv = 1'b1;
         tick(1);
         chk("R4 fault before rise seen", int'(fault_o), 1);
         tick(2);
         chk("R4 rise withdraws fault", int'(fault_o), 0);
         chk("R4 bridges still off", int'(bridge_en_o), 0);
         mute_drv = 1'b0;
         tick(2);
         chk("R4 waiting for fall", int'(bridge_en_o), 0);
         tick(1);
         chk("R4 fall releases", int'(bridge_en_o), 1);
      end

      // R4 R11: reset clears trip
      oc_flag = 4'b0011;
      tick(1);
      oc_flag = '0;
      chk("R3 two flags trip", int'(fault_o), 1);
      rst_n = 1'b0;
      tick(1);
      chk("R11 reset clears trip", int'(fault_o), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R11 muted after reset", int'(bridge_en_o), 0);
      tick(3);
      chk("R4 runs after reset", int'(bridge_en_o), 1);

      // R4: mute tied to fault, self recovery
      tie_fb = 1'b1;
      oc_flag = 4'b1000;
      tick(1);
      oc_flag = '0;
      chk("R4 tied trip", int'(fault_o), 1);
      tick(20);
      chk("R4 tied self clear fault", int'(fault_o), 0);
      chk("R4 tied self clear bridge", int'(bridge_en_o), 1);
      tie_fb = 1'b0;
      mute_drv = 1'b0;
      tick(2);

      // R8: sleep overrides mute low
      sleep_pin = 1'b1;
      tick(1);
      chk("R8 sleep one edge", int'(lowpwr_o), 0);
      tick(1);
      chk("R8 sleep low power", int'(lowpwr_o), 1);
      chk("R8 sleep hiz", int'(hiz_o), 1);
      chk("R8 sleep bridges off", int'(bridge_en_o), 0);
      // R9: flag in sleep does not latch
      oc_flag = 4'b0100;
      tick(1);
      oc_flag = '0;
      chk("R9 no latch in sleep", int'(fault_o), 0);
      sleep_pin = 1'b0;
      tick(3);
      chk("R9 no latch after sleep", int'(fault_o), 0);
      chk("R8 wake runs", int'(bridge_en_o), 1);

      // R9: trip survives mute toggle during sleep
      oc_flag = 4'b0001;
      tick(1);
      oc_flag = '0;
      sleep_pin = 1'b1;
      tick(3);
      mute_toggle();
      sleep_pin = 1'b0;
      tick(3);
      chk("R9 trip held through sleep", int'(fault_o), 1);
      mute_toggle();
      chk("R4 cleared after wake toggle", int'(fault_o), 0);
      chk("R4 runs after wake toggle", int'(bridge_en_o), 1);

      // R10: overload indicator
      ovl_in = 1'b1;
      tick(1);
      chk("R10 overload one edge", int'(ovl_n_o), 1);
      tick(1);
      chk("R10 overload shown", int'(ovl_n_o), 0);
      ovl_in = 1'b0;
      tick(2);
      chk("R10 overload gone", int'(ovl_n_o), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule